// File: doc/BRIEF.md
# Three-Level Strap Pin Sensor

This block reads a board strap on one pad of a bank of general-purpose pins. The strap can be tied high, tied low, or left open. To tell these apart, the block drives the pad's own weak pull resistors and watches what the pad does. On a start pulse it forces the chosen pad into input mode and turns on the weak pull-up. It waits a programmable number of clock cycles for the line to settle and samples the pad. It then moves to the weak pull-down, waits again and takes a second sample.

If the two samples agree, they give the strapped level. If they differ, the pad followed the internal pull, so it is open. The block returns a 2-bit code together with a one-cycle done strobe. It leaves the pad's pull matched to the strap: pull-up for a high strap, and pull-down in every other case.

An index beyond the bank is refused with an error code and changes no pull. The pad level arrives already synchronised, one bit per pin. The block keeps the pull and input-force settings of every pin and only ever changes the selected one.

Top module: `strap_probe_ctrl`

## Requirements
- R1: After reset, done_o is 0, result_o is 00, and every bit of input_force_o, pull_up_o and pull_dn_o is 0.
- R2: A start pulse in idle with a valid index (below NUM_PINS) sets input force and pull-up, and clears pull-down, on that pin at the clock edge that samples the start.
- R3: Let W = max(settle_cycles_i, 1), where settle_cycles_i is captured at start and later changes to it are ignored. The first sample is taken after W cycles under pull-up. The pull then switches to pull-down for W cycles and the second sample is taken. done_o rises 2W+3 clock edges after the edge that accepted the start.
- R4: The result code is 00 when both samples are low, 01 when both are high, and 10 when they differ (open pad).
- R5: At done, a 01 result leaves pull-up on and pull-down off on the pin. Results 00 and 10 leave pull-down on and pull-up off. Input force stays on in all three cases.
- R6: A start with an index at or above NUM_PINS gives result 11 with done_o one edge after the accepting edge, and changes no pull or input-force bit.
- R7: done_o is high for exactly one cycle per accepted start, and result_o is valid while it is high.
- R8: A start pulse arriving while a probe is running is ignored: the running probe's result and timing are unchanged, and the pulled pin's settings are not touched.
- R9: Pins other than the selected one keep their input-force and pull settings through a probe.
- R10: Pull-up and pull-down are never both enabled on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| pin_idx_i | input | IDX_W | Pin to probe |
| pad_level_i | input | NUM_PINS | Synchronised pad levels, one per pin |
| settle_cycles_i | input | CNT_W | Settle time in clock cycles (0 behaves as 1) |
| input_force_o | output | NUM_PINS | Per-pin force-to-input control |
| pull_up_o | output | NUM_PINS | Per-pin weak pull-up enable |
| pull_dn_o | output | NUM_PINS | Per-pin weak pull-down enable |
| result_o | output | 2 | 00 low, 01 high, 10 open, 11 bad index |
| done_o | output | 1 | One-cycle result strobe |

## Verification
If the sequencer state were wrong, the pull outputs would switch at the wrong edge, so done_o would arrive off the 2W+3 mark. The bench measures that latency for every run. An open pad is modelled as following the pulls, so a swapped sample order or a stale sample shows at once as a wrong code. A corrupted pull write shows as a wrong final pull pattern on the probed pin or on a neighbour, and the bench compares every pin's settings at done.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PU_WAIT = 3'd1,
        ST_SMP_HI  = 3'd2,
        ST_PD_WAIT = 3'd3,
        ST_SMP_LO  = 3'd4,
        ST_RESOLVE = 3'd5
    } probe_state_e;

    typedef enum logic [1:0] {
        RES_LOW   = 2'b00,
        RES_HIGH  = 2'b01,
        RES_FLOAT = 2'b10,
        RES_ERR   = 2'b11
    } strap_res_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_UP   = 2'd1,
        PULL_DOWN = 2'd2
    } pull_cmd_e;

    typedef struct packed {
        logic force_in;
        logic up;
        logic dn;
    } pin_cfg_t;

    function automatic strap_res_e classify(input logic hi_smp, input logic lo_smp);
        if (hi_smp && lo_smp) begin
            return RES_HIGH;
        end else if (!hi_smp && !lo_smp) begin
            return RES_LOW;
        end
        return RES_FLOAT;
    endfunction

endpackage

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dec_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load_i) begin
            rem_d = (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end else if (dec_i && rem_q != '0) begin
            rem_d = rem_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign expired_o = (rem_q == '0);

    // R3
    timer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !load_i && !expired_o) |=> (rem_q < $past(rem_q)));

endmodule

// File: rtl/strap_pull_bank.sv
module strap_pull_bank
    import strap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    wr_pin_i,
    input  pull_cmd_e           wr_cmd_i,
    output logic [NUM_PINS-1:0] force_in_o,
    output logic [NUM_PINS-1:0] up_o,
    output logic [NUM_PINS-1:0] dn_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_cfg_t cfg_d, cfg_q;
        logic     hit;

        assign hit = wr_i && (wr_pin_i == IDX_W'(g));

        always_comb begin
            cfg_d = cfg_q;
            if (hit) begin
                cfg_d.force_in = 1'b1;
                cfg_d.up       = (wr_cmd_i == PULL_UP);
                cfg_d.dn       = (wr_cmd_i == PULL_DOWN);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cfg_q <= '0;
            end else begin
                cfg_q <= cfg_d;
            end
        end

        assign force_in_o[g] = cfg_q.force_in;
        assign up_o[g]       = cfg_q.up;
        assign dn_o[g]       = cfg_q.dn;
    end

    // R10
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_o & dn_o) == '0);

    // R9
    untouched_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ($stable(up_o) && $stable(dn_o) && $stable(force_in_o)));

endmodule

// File: rtl/strap_level_pick.sv
module strap_level_pick #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] pad_i,
    input  logic [NUM_PINS-1:0] sel_oh_i,
    output logic                level_o
);
    assign level_o = |(pad_i & sel_oh_i);
endmodule

// File: rtl/strap_probe_ctrl.sv
module strap_probe_ctrl
    import strap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    pin_idx_i,
    input  logic [NUM_PINS-1:0] pad_level_i,
    input  logic [CNT_W-1:0]    settle_cycles_i,
    output logic [NUM_PINS-1:0] input_force_o,
    output logic [NUM_PINS-1:0] pull_up_o,
    output logic [NUM_PINS-1:0] pull_dn_o,
    output logic [1:0]          result_o,
    output logic                done_o
);
    typedef struct packed {
        probe_state_e     state;
        logic [IDX_W-1:0] pin;
        logic [CNT_W-1:0] settle;
        logic             hi;
        logic             lo;
        logic             err;
        logic             done;
        strap_res_e       result;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_dec;
    logic             tmr_expired;
    logic             bank_wr;
    logic [IDX_W-1:0] bank_pin;
    pull_cmd_e        bank_cmd;
    logic [NUM_PINS-1:0] sel_oh;
    logic             pad_sel;
    strap_res_e       verdict;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            sel_oh[i] = (ctrl_q.pin == IDX_W'(i));
        end
    end

    strap_level_pick #(.NUM_PINS(NUM_PINS)) u_pick (
        .pad_i    (pad_level_i),
        .sel_oh_i (sel_oh),
        .level_o  (pad_sel)
    );

    strap_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .dec_i     (tmr_dec),
        .expired_o (tmr_expired)
    );

    strap_pull_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bank_wr),
        .wr_pin_i   (bank_pin),
        .wr_cmd_i   (bank_cmd),
        .force_in_o (input_force_o),
        .up_o       (pull_up_o),
        .dn_o       (pull_dn_o)
    );

    assign verdict = classify(ctrl_q.hi, ctrl_q.lo);

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        tmr_load    = 1'b0;
        tmr_len     = ctrl_q.settle;
        tmr_dec     = 1'b0;
        bank_wr     = 1'b0;
        bank_pin    = ctrl_q.pin;
        bank_cmd    = PULL_NONE;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                bank_pin = pin_idx_i;
                if (start_i) begin
                    ctrl_d.pin = pin_idx_i;
                    if (int'(pin_idx_i) >= NUM_PINS) begin
                        ctrl_d.err   = 1'b1;
                        ctrl_d.state = ST_RESOLVE;
                    end else begin
                        ctrl_d.err    = 1'b0;
                        ctrl_d.settle = settle_cycles_i;
                        tmr_load      = 1'b1;
                        tmr_len       = settle_cycles_i;
                        bank_wr       = 1'b1;
                        bank_cmd      = PULL_UP;
                        ctrl_d.state  = ST_PU_WAIT;
                    end
                end
            end
            ST_PU_WAIT: begin
                tmr_dec = 1'b1;
                if (tmr_expired) begin
                    ctrl_d.state = ST_SMP_HI;
                end
            end
            ST_SMP_HI: begin
                ctrl_d.hi    = pad_sel;
                bank_wr      = 1'b1;
                bank_cmd     = PULL_DOWN;
                tmr_load     = 1'b1;
                ctrl_d.state = ST_PD_WAIT;
            end
            ST_PD_WAIT: begin
                tmr_dec = 1'b1;
                if (tmr_expired) begin
                    ctrl_d.state = ST_SMP_LO;
                end
            end
            ST_SMP_LO: begin
                ctrl_d.lo    = pad_sel;
                ctrl_d.state = ST_RESOLVE;
            end
            ST_RESOLVE: begin
                ctrl_d.done   = 1'b1;
                ctrl_d.result = ctrl_q.err ? RES_ERR : verdict;
                if (!ctrl_q.err && verdict == RES_HIGH) begin
                    bank_wr  = 1'b1;
                    bank_cmd = PULL_UP;
                end
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: ST_IDLE, result: RES_LOW, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign result_o = ctrl_q.result;
    assign done_o   = ctrl_q.done;

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && result_o == RES_ERR) |->
            (pull_up_o == $past(pull_up_o) && pull_dn_o == $past(pull_dn_o)
             && input_force_o == $past(input_force_o)));

    // R8
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.state != ST_IDLE) |=> $stable(ctrl_q.pin));

    // R2
    hi_sample_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.state == ST_SMP_HI) |->
            ((pull_up_o & sel_oh) == sel_oh && (pull_dn_o & sel_oh) == '0
             && (input_force_o & sel_oh) == sel_oh));

    // R3
    lo_sample_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.state == ST_SMP_LO) |->
            ((pull_dn_o & sel_oh) == sel_oh && (pull_up_o & sel_oh) == '0));

    // R5
    final_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && result_o != RES_ERR) |->
            (((result_o == RES_HIGH) ? pull_up_o : pull_dn_o) & sel_oh) == sel_oh);

endmodule

// File: tb/strap_probe_ctrl_tb_top.sv
module strap_probe_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int IW   = 3;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] pin_idx = '0;
    logic [NP-1:0] pad;
    logic [CW-1:0] settle = '0;
    logic [NP-1:0] force_in, pu, pd;
    logic [1:0]    result;
    logic          done;

    int ext_mode [NP];
    bit exp_in [NP];
    bit exp_pu [NP];
    bit exp_pd [NP];
    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            if (ext_mode[i] == 0)      pad[i] = 1'b0;
            else if (ext_mode[i] == 1) pad[i] = 1'b1;
            else                       pad[i] = pu[i];
        end
    end

    strap_probe_ctrl #(.NUM_PINS(NP), .IDX_W(IW), .CNT_W(CW)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .start_i         (start),
        .pin_idx_i       (pin_idx),
        .pad_level_i     (pad),
        .settle_cycles_i (settle),
        .input_force_o   (force_in),
        .pull_up_o       (pu),
        .pull_dn_o       (pd),
        .result_o        (result),
        .done_o          (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req);
        for (int i = 0; i < NP; i++) begin
            check(force_in[i] == exp_in[i], req, int'(force_in[i]), int'(exp_in[i]));
            check(pu[i] == exp_pu[i], req, int'(pu[i]), int'(exp_pu[i]));
            check(pd[i] == exp_pd[i], req, int'(pd[i]), int'(exp_pd[i]));
        end
    endtask

    task automatic run_probe(input int pin, input int n, input bit inject, input int inj_pin);
        int k;
        int w;
        int exp_lat;
        int exp_res;
        bit hi;
        bit lo;
        bit inj_up_seen;
        w = (n == 0) ? 1 : n;
        @(negedge clk);
        start = 1'b1; pin_idx = IW'(pin); settle = CW'(n);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        settle = CW'(n + 7);
        if (pin < NP) begin
            // R2: pull-up applied at the accepting edge
            check(pu[pin] && !pd[pin] && force_in[pin], "R2", int'({force_in[pin], pu[pin], pd[pin]}), 6);
        end
        k = 0;
        inj_up_seen = 1'b0;
        while (!done && k < 64) begin
            if (inject && k == 2) begin
                start = 1'b1; pin_idx = IW'(inj_pin);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            k++;
            @(negedge clk);
            if (inject && (pu[inj_pin] != exp_pu[inj_pin] || pd[inj_pin] != exp_pd[inj_pin]))
                inj_up_seen = 1'b1;
        end
        start = 1'b0;
        if (pin >= NP) begin
            exp_lat = 1;
            exp_res = 3;
        end else begin
            exp_lat = 2 * w + 3;
            hi = (ext_mode[pin] != 0);
            lo = (ext_mode[pin] == 1);
            exp_res = (hi && lo) ? 1 : (!hi && !lo) ? 0 : 2;
            exp_in[pin] = 1'b1;
            exp_pu[pin] = (exp_res == 1);
            exp_pd[pin] = (exp_res != 1);
        end
        if (pin >= NP) begin
            // R6: error code, one-edge latency
            check(done && result == 2'b11, "R6", int'(result), exp_res);
            check(k == exp_lat, "R6", k, exp_lat);
        end else begin
            // R4: classification code
            check(done && int'(result) == exp_res, "R4", int'(result), exp_res);
            // R3: settle timing 2W+3
            check(k == exp_lat, "R3", k, exp_lat);
        end
        if (inject) begin
            // R8: busy start ignored
            check(!inj_up_seen, "R8", int'(inj_up_seen), 0);
            check(int'(result) == exp_res && k == exp_lat, "R8", k, exp_lat);
        end
        // R5 R6 R9: pull pattern on the probed pin and all neighbours
        check_pins(pin >= NP ? "R6" : "R5_R9");
        @(posedge clk);
        @(negedge clk);
        // R7: single-cycle strobe
        check(!done, "R7", int'(done), 0);
        if (inject) begin
            check_pins("R8");
        end
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin
            ext_mode[i] = 2; exp_in[i] = 0; exp_pu[i] = 0; exp_pd[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!done && result == 2'b00, "R1", int'({done, result}), 0);
        check(force_in == '0 && pu == '0 && pd == '0, "R1", int'({force_in, pu, pd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 is also guarded by an assertion in the pull bank
        for (int n = 0; n < 4; n++) begin
            int sv;
            sv = (n == 3) ? 5 : n;
            for (int pin = 0; pin < 8; pin++) begin
                for (int m = 0; m < 3; m++) begin
                    if (pin < NP) ext_mode[pin] = m;
                    run_probe(pin, sv, 1'b0, 0);
                end
            end
        end
        ext_mode[1] = 1;
        ext_mode[2] = 0;
        run_probe(1, 3, 1'b1, 2);
        ext_mode[3] = 2;
        run_probe(3, 2, 1'b1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule